// File: doc/BRIEF.md
# Keyboard-style mailbox register controller

This block holds four byte-wide mailbox channels between a host and a management processor. Each channel has an inbound data register, an outbound data register and a status register. The management processor reaches all of them, and the controller's enable and interrupt-enable words, through a 32-bit register port. The host side has a narrow port that picks a channel, deposits an inbound byte or collects the outbound byte.

The status flags are not written directly. Accesses from the opposite side set and clear them. A host deposit marks the inbound buffer full and can raise that channel's interrupt line. A management read of the inbound register drains the buffer and lowers the line. A management write of the outbound register marks the outbound buffer full, and a host collect clears that flag. Each channel has its own enable rule, and channel 3 needs two enable bits. A pending bitmask latches the channel lines and drives one combined interrupt.

Top module: `kcs_mailbox_ctrl`

## Requirements
- R1: After reset every register reads zero except the word at byte 0x88, which reads the parameter CTRL7_RST. All interrupt outputs are low.
- R2: Per-channel byte offsets are as follows. Inbound data is at 0x24, 0x28, 0x2C and 0x114. Outbound data is at 0x30, 0x34, 0x38 and 0x118. Status is at 0x3C, 0x40, 0x44 and 0x11C. In a status word, bit 0 is outbound-full, bit 1 is inbound-full and bit 3 is command/data.
- R3: A host write to channel c stores the byte, zero-extended, in that channel's inbound register and sets its inbound-full flag on the next clock edge.
- R4: A management read of an inbound register returns its value in the same cycle and clears inbound-full. If the flag was set, it also drops that channel's interrupt line.
- R5: A management write of an outbound register stores the word and sets outbound-full. A host read of channel c returns bits 7:0 of that outbound register in the same cycle and clears outbound-full.
- R6: The channel enables are as follows. Channel 1 is bit 5 of word 0x00 and channel 2 is bit 6 of word 0x00. Channel 3 needs both bit 7 of word 0x00 and bit 2 of word 0x10. Channel 4 is bit 0 of word 0x100.
- R7: The inbound interrupt enables are bits 1, 2 and 3 of word 0x08 for channels 1 to 3, and bit 1 of word 0x100 for channel 4. A host write raises the channel line on the next edge only if that channel is enabled and its interrupt enable is set.
- R8: The combined interrupt is the OR of a pending bitmask. Each pending bit copies its channel line one cycle later.
- R9: Byte addresses 0x260 and above read zero, and writes to them change nothing.
- R10: A host write and a management read of the same channel's inbound register in one cycle leave inbound-full set and keep the channel line high if it is already high.
- R11: A management write to a status word changes every bit except bits 0 and 1.
- R12: A management outbound write and a host read of the same channel in one cycle leave outbound-full set.
- R13: All other words in range, including the control words, read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Management access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Management write data |
| bus_rdata | output | 32 | Management read data, same cycle |
| host_wr | input | 1 | Host deposits an inbound byte |
| host_rd | input | 1 | Host collects the outbound byte |
| host_chan | input | 2 | Host channel select, 0 to 3 |
| host_wdata | input | 8 | Host inbound byte |
| host_rdata | output | 8 | Outbound byte of the selected channel |
| irq_chan | output | 4 | Per-channel inbound-full interrupt lines |
| irq_agg | output | 1 | Combined interrupt |

## Verification
Random sequences mix host deposits and collects, management data reads and writes, status writes and random control words over all four channels. A golden model checks them, so the flag, enable and interrupt rules are tested under many enable combinations. Directed cases cover the channel 3 enable with only one of its two bits set, and a deposit made while interrupts are disabled. Two more directed cases drive same-cycle conflicts on one channel, so a design in which the clear wins is caught. A further directed case uses out-of-range addresses, so a design that drops the upper address bits and aliases into the map is caught.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
    localparam int NUM_CH     = 4;
    localparam int BUS_W      = 32;
    localparam int HOST_W     = 8;
    localparam int SPAN_BYTES = 'h260;
    localparam int CTRL7_BYTE = 'h88;
    localparam int EN_A_BYTE  = 'h00;
    localparam int IE_BYTE    = 'h08;
    localparam int EN_B_BYTE  = 'h10;
    localparam int CH4_BYTE   = 'h100;
    localparam int OBF_BIT    = 0;
    localparam int IBF_BIT    = 1;
    localparam int CD_BIT     = 3;

    function automatic int idr_byte(input int c);
        return (c < 3) ? ('h24 + 4 * c) : 'h114;
    endfunction

    function automatic int odr_byte(input int c);
        return (c < 3) ? ('h30 + 4 * c) : 'h118;
    endfunction

    function automatic int str_byte(input int c);
        return (c < 3) ? ('h3C + 4 * c) : 'h11C;
    endfunction
endpackage

// File: rtl/kcs_addr_dec.sv
module kcs_addr_dec
    import kcs_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SPAN   = SPAN_BYTES,
    parameter int WORD_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [WORD_W-1:0] word,
    output logic [NUM_CH-1:0] idr_hit,
    output logic [NUM_CH-1:0] odr_hit,
    output logic [NUM_CH-1:0] str_hit
);
    localparam int WA_W = ADDR_W - 2;

    assign in_range = ({{(32-ADDR_W){1'b0}}, addr} < 32'(SPAN));
    assign word     = addr[WORD_W+1:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign idr_hit[c] = in_range && (addr[ADDR_W-1:2] == WA_W'(idr_byte(c) / 4));
        assign odr_hit[c] = in_range && (addr[ADDR_W-1:2] == WA_W'(odr_byte(c) / 4));
        assign str_hit[c] = in_range && (addr[ADDR_W-1:2] == WA_W'(str_byte(c) / 4));
    end
endmodule

// File: rtl/kcs_chan_gate.sv
module kcs_chan_gate
    import kcs_pkg::*;
(
    input  logic [BUS_W-1:0]  en_a_word,
    input  logic [BUS_W-1:0]  ie_word,
    input  logic [BUS_W-1:0]  en_b_word,
    input  logic [BUS_W-1:0]  ch4_word,
    output logic [NUM_CH-1:0] chan_en,
    output logic [NUM_CH-1:0] ibf_ie
);
    logic [NUM_CH-1:0] ie_raw;

    always_comb begin
        chan_en[0] = en_a_word[5];
        chan_en[1] = en_a_word[6];
        chan_en[2] = en_a_word[7] & en_b_word[2];
        chan_en[3] = ch4_word[0];
        ie_raw     = {ch4_word[1], ie_word[3], ie_word[2], ie_word[1]};
        ibf_ie     = chan_en & ie_raw;
    end
endmodule

// File: rtl/kcs_irq_or.sv
module kcs_irq_or #(
    parameter int N = 4
) (
    input  logic [N-1:0] pend,
    output logic         agg
);
    assign agg = |pend;
endmodule

// File: rtl/kcs_mailbox_ctrl.sv
module kcs_mailbox_ctrl
    import kcs_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [31:0] CTRL7_RST = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_chan,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [3:0]        irq_chan,
    output logic              irq_agg
);
    localparam int NW      = SPAN_BYTES / 4;
    localparam int WORD_W  = $clog2(NW);
    localparam int CTRL7_W = CTRL7_BYTE / 4;
    localparam logic [BUS_W-1:0] FLAG_MASK = (BUS_W'(1) << OBF_BIT) | (BUS_W'(1) << IBF_BIT);

    typedef struct packed {
        logic [NW-1:0][BUS_W-1:0] regs;
        logic [NUM_CH-1:0]        irq;
        logic [NUM_CH-1:0]        pend;
    } state_t;

    state_t st_q, st_d;

    logic              in_range;
    logic [WORD_W-1:0] word;
    logic [NUM_CH-1:0] idr_hit, odr_hit, str_hit;
    logic [NUM_CH-1:0] chan_en, ibf_ie;
    logic              mgmt_wr, mgmt_rd;

    kcs_addr_dec #(.ADDR_W(ADDR_W), .SPAN(SPAN_BYTES), .WORD_W(WORD_W)) u_dec (
        .addr     (bus_addr),
        .in_range (in_range),
        .word     (word),
        .idr_hit  (idr_hit),
        .odr_hit  (odr_hit),
        .str_hit  (str_hit)
    );

    kcs_chan_gate u_gate (
        .en_a_word (st_q.regs[EN_A_BYTE/4]),
        .ie_word   (st_q.regs[IE_BYTE/4]),
        .en_b_word (st_q.regs[EN_B_BYTE/4]),
        .ch4_word  (st_q.regs[CH4_BYTE/4]),
        .chan_en   (chan_en),
        .ibf_ie    (ibf_ie)
    );

    kcs_irq_or #(.N(NUM_CH)) u_or (
        .pend (st_q.pend),
        .agg  (irq_agg)
    );

    assign mgmt_wr = bus_sel & bus_wr & in_range;
    assign mgmt_rd = bus_sel & ~bus_wr & in_range;

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.irq;

        // plain register write; status keeps its two hardware flags
        if (mgmt_wr) begin
            if (|str_hit) begin
                st_d.regs[word] = (bus_wdata & ~FLAG_MASK) | (st_q.regs[word] & FLAG_MASK);
            end else begin
                st_d.regs[word] = bus_wdata;
            end
        end

        for (int c = 0; c < NUM_CH; c++) begin
            // clears first
            if (mgmt_rd && idr_hit[c]) begin
                st_d.regs[str_byte(c)/4][IBF_BIT] = 1'b0;
                if (st_q.regs[str_byte(c)/4][IBF_BIT]) begin
                    st_d.irq[c] = 1'b0;
                end
            end
            if (host_rd && (32'(host_chan) == c)) begin
                st_d.regs[str_byte(c)/4][OBF_BIT] = 1'b0;
            end
            // sets win over clears
            if (mgmt_wr && odr_hit[c]) begin
                st_d.regs[str_byte(c)/4][OBF_BIT] = 1'b1;
            end
            if (host_wr && (32'(host_chan) == c)) begin
                st_d.regs[idr_byte(c)/4]          = {{(BUS_W-HOST_W){1'b0}}, host_wdata};
                st_d.regs[str_byte(c)/4][IBF_BIT] = 1'b1;
                if (ibf_ie[c]) begin
                    st_d.irq[c] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.regs[CTRL7_W]  <= CTRL7_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = in_range ? st_q.regs[word] : '0;
    assign host_rdata = st_q.regs[odr_byte(32'(host_chan))/4][HOST_W-1:0];
    assign irq_chan   = st_q.irq;
endmodule

// File: rtl/kcs_mailbox_sva.sv
module kcs_mailbox_sva
    import kcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              host_wr,
    input logic [1:0]        host_chan,
    input logic [3:0]        irq_chan,
    input logic              irq_agg
);
    localparam int WA_W = ADDR_W - 2;

    assert_agg_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_chan) |=> irq_agg);
    assert_agg_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq_chan) |=> !irq_agg);
    assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && ({{(32-ADDR_W){1'b0}}, bus_addr} >= 32'(SPAN_BYTES))) |-> (bus_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_chan[c]) |-> $past(host_wr && (host_chan == 2'(c))));
        assert_irq_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_chan[c]) |-> $past(bus_sel && !bus_wr &&
                                         (bus_addr[ADDR_W-1:2] == WA_W'(idr_byte(c) / 4))));
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_chan[c] && host_wr && (host_chan == 2'(c))) |=> irq_chan[c]);
    end
endmodule

bind kcs_mailbox_ctrl kcs_mailbox_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .host_wr   (host_wr),
    .host_chan (host_chan),
    .irq_chan  (irq_chan),
    .irq_agg   (irq_agg)
);

// File: tb/kcs_mailbox_ctrl_tb.sv
module kcs_mailbox_ctrl_tb_top;
    localparam logic [31:0] C7 = 32'hC0DE_0A55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0, host_wr = 0, host_rd = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  host_chan = '0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic [3:0]  irq_chan;
    logic        irq_agg;

    always #10 clk = ~clk;

    kcs_mailbox_ctrl #(.ADDR_W(12), .CTRL7_RST(C7)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_chan(host_chan),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_chan(irq_chan), .irq_agg(irq_agg)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_idr [4], m_odr [4], m_str [4];
    logic [31:0] m_c0 = 0, m_c2 = 0, m_c4 = 0, m_cb = 0;
    logic [3:0]  m_irq = 0;
    logic [31:0] brd;
    logic [7:0]  hrd;

    function automatic logic [11:0] a_idr(int c); return (c < 3) ? 12'(36 + 4*c) : 12'h114; endfunction
    function automatic logic [11:0] a_odr(int c); return (c < 3) ? 12'(48 + 4*c) : 12'h118; endfunction
    function automatic logic [11:0] a_str(int c); return (c < 3) ? 12'(60 + 4*c) : 12'h11C; endfunction

    function automatic bit ch_en(int c);
        case (c)
            0: return m_c0[5];
            1: return m_c0[6];
            2: return m_c0[7] & m_c4[2];
            default: return m_cb[0];
        endcase
    endfunction
    function automatic bit ch_ie(int c);
        return ch_en(c) && ((c < 3) ? m_c2[c+1] : m_cb[1]);
    endfunction

    function automatic logic [31:0] model_rd(logic [11:0] a);
        for (int c = 0; c < 4; c++) begin
            if (a == a_idr(c)) return m_idr[c];
            if (a == a_odr(c)) return m_odr[c];
            if (a == a_str(c)) return m_str[c];
        end
        case (a)
            12'h000: return m_c0;
            12'h008: return m_c2;
            12'h010: return m_c4;
            12'h100: return m_cb;
            12'h088: return C7;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic bs, input logic bw, input logic [11:0] ba, input logic [31:0] bd,
                       input logic hw, input logic hr, input logic [1:0] hc, input logic [7:0] hd);
        @(negedge clk);
        bus_sel = bs; bus_wr = bw; bus_addr = ba; bus_wdata = bd;
        host_wr = hw; host_rd = hr; host_chan = hc; host_wdata = hd;
        #5;
        brd = bus_rdata; hrd = host_rdata;
        @(posedge clk);
        #2;
        bus_sel = 0; bus_wr = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic post(logic [3:0] prev);
        chk("R7 irq_chan", 32'(irq_chan), 32'(m_irq));
        chk("R8 irq_agg", 32'(irq_agg), 32'(|prev));
    endtask

    task automatic mw(logic [11:0] a, logic [31:0] d);
        logic [3:0] prev = m_irq;
        cyc(1, 1, a, d, 0, 0, 0, 0);
        for (int c = 0; c < 4; c++) begin
            if (a == a_odr(c)) begin m_odr[c] = d; m_str[c][0] = 1; end
            if (a == a_str(c)) m_str[c] = (d & ~32'h3) | (m_str[c] & 32'h3);
            if (a == a_idr(c)) m_idr[c] = d;
        end
        case (a)
            12'h000: m_c0 = d;
            12'h008: m_c2 = d;
            12'h010: m_c4 = d;
            12'h100: m_cb = d;
            default: ;
        endcase
        post(prev);
    endtask

    task automatic mr(string tag, logic [11:0] a);
        logic [3:0] prev = m_irq;
        logic [31:0] e = model_rd(a);
        cyc(1, 0, a, 0, 0, 0, 0, 0);
        chk(tag, brd, e);
        for (int c = 0; c < 4; c++)
            if (a == a_idr(c)) begin
                if (m_str[c][1]) m_irq[c] = 0;
                m_str[c][1] = 0;
            end
        post(prev);
    endtask

    task automatic hw_(int c, logic [7:0] d);
        logic [3:0] prev = m_irq;
        cyc(0, 0, 0, 0, 1, 0, 2'(c), d);
        m_idr[c] = {24'h0, d}; m_str[c][1] = 1;
        if (ch_ie(c)) m_irq[c] = 1;
        post(prev);
    endtask

    task automatic hr_(string tag, int c);
        logic [3:0] prev = m_irq;
        cyc(0, 0, 0, 0, 0, 1, 2'(c), 0);
        chk(tag, 32'(hrd), 32'(m_odr[c][7:0]));
        m_str[c][0] = 0;
        post(prev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] p;
        void'($urandom(32'd1234));
        for (int c = 0; c < 4; c++) begin m_idr[c] = 0; m_odr[c] = 0; m_str[c] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1 reset state
        chk("R1 irq_chan", 32'(irq_chan), 0);
        chk("R1 irq_agg", 32'(irq_agg), 0);
        mr("R1 ctrl7", 12'h088);
        mr("R1 str4", 12'h11C);
        mr("R1 ctrl0", 12'h000);

        // R2/R5 outbound path per channel, R3/R4 inbound path
        for (int c = 0; c < 4; c++) begin
            mw(a_odr(c), 32'hA500_0010 + 32'(c));
            mr("R2 status obf", a_str(c));
            hr_("R5 host read", c);
            mr("R5 obf cleared", a_str(c));
            hw_(c, 8'h40 + 8'(c));
            mr("R3 status ibf", a_str(c));
            mr("R4 idr read", a_idr(c));
            mr("R4 ibf cleared", a_str(c));
        end

        // R6/R7 channel 3 needs both bits
        mw(12'h008, 32'h0000_000E);
        mw(12'h000, 32'h0000_0080);
        hw_(2, 8'h33);
        chk("R6 ch3 half enable", 32'(irq_chan[2]), 0);
        mr("R4 drain", a_idr(2));
        mw(12'h010, 32'h0000_0004);
        hw_(2, 8'h34);
        chk("R6 ch3 full enable", 32'(irq_chan[2]), 1);
        mr("R4 drain irq", a_idr(2));
        chk("R4 irq low", 32'(irq_chan[2]), 0);
        // R7 enabled channel with interrupt bit off
        mw(12'h100, 32'h0000_0001);
        hw_(3, 8'h77);
        chk("R7 ie off", 32'(irq_chan[3]), 0);
        mw(12'h100, 32'h0000_0003);
        mr("R4 drain ch4", a_idr(3));

        // R10 set wins over same-cycle drain
        mw(12'h000, 32'h0000_0020);
        mw(12'h008, 32'h0000_0002);
        hw_(0, 8'h11);
        p = m_irq;
        cyc(1, 0, a_idr(0), 0, 1, 0, 2'd0, 8'h22);
        chk("R10 old data", brd, 32'h11);
        m_idr[0] = 32'h22;
        post(p);
        mr("R10 ibf kept", a_str(0));
        mr("R10 new data", a_idr(0));

        // R12 outbound write vs host collect
        p = m_irq;
        cyc(1, 1, a_odr(1), 32'h0000_00BB, 0, 1, 2'd1, 0);
        chk("R12 host byte", 32'(hrd), 32'(m_odr[1][7:0]));
        m_odr[1] = 32'hBB; m_str[1][0] = 1;
        post(p);
        mr("R12 obf kept", a_str(1));

        // R11 status write mask
        mw(a_str(3), 32'hFFFF_FFFF);
        mr("R11 status mask", a_str(3));
        mw(a_str(3), 32'h0);
        mr("R11 status clear", a_str(3));

        // R9 out of range
        mw(12'h260, 32'hDEAD_BEEF);
        mr("R9 oob read", 12'h260);
        mr("R9 oob alias", 12'h000);
        mr("R9 far read", 12'hFFC);

        // R13 control readback
        mw(12'h010, 32'h1234_5670);
        mr("R13 ctrl readback", 12'h010);

        // random mix
        for (int i = 0; i < 800; i++) begin
            int c = int'($urandom_range(0, 3));
            case ($urandom_range(0, 8))
                0, 1: hw_(c, 8'($urandom));
                2:    hr_("R5 rand host read", c);
                3:    mr("R4 rand idr", a_idr(c));
                4:    mw(a_odr(c), $urandom);
                5:    mr("R2 rand status", a_str(c));
                6:    mw(a_str(c), $urandom);
                7: begin
                    case ($urandom_range(0, 3))
                        0: mw(12'h000, $urandom);
                        1: mw(12'h008, $urandom);
                        2: mw(12'h010, $urandom);
                        default: mw(12'h100, $urandom);
                    endcase
                end
                default: mr("R13 rand ctrl", ($urandom_range(0, 1) == 0) ? 12'h008 : 12'h100);
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule